// File: doc/BRIEF.md
# Network-Termination Loop Activation Sequencer

This block is the control state machine on the network-termination side of a two-wire subscriber loop transceiver. The far (line-terminal) end starts an activation by sending a wake-up tone. The sequencer reports that tone to the host. Once the host has powered the device up and issued an activation request, the sequencer advances on its own through superframe synchronisation and full activation. It also watches the whole attempt with a supervision timer.

The analog front end, the framer and the register file are outside the block. Their results arrive as simple flags:
- tone present;
- superframe sync held;
- a strobe once per received frame, with the received act and dea overhead bits;
- far-end signal present.

The block drives single-cycle interrupt strobes, an active-low line-signal-detect pin, the act bit to transmit, a transmit enable and a three-bit state code. A received overhead bit counts only after it has matched on three frames in a row. If the supervision timer runs out, the block gives an error strobe and then a deactivation strobe, and it passes through a fault state back to reset.

Top module: `ntact_seq`

## Requirements
- R1: After synchronous reset, state_o is 0 (reset), lsd_n is 1, tx_en is 0, tx_act is 0 and every interrupt output is 0.
- R2: Each rising edge of wake_tone produces one irq_lsd pulse, whether pwr_up is 0 or 1.
- R3: A wake_tone rising edge while pwr_up is 0 drives lsd_n to 0. lsd_n then stays at 0 until pwr_up is 1, and a tone edge seen while pwr_up is 1 leaves lsd_n at 1.
- R4: In state 0, cmd_ar with pwr_up=1 moves the block to state 1 (activating) and starts the supervision timer. cmd_ar with pwr_up=0 is ignored, and the state stays 0.
- R5: In state 1, sf_sync=1 moves the block to state 2 (synced) with one irq_ap pulse. tx_en becomes 1 and tx_act is 0.
- R6: tx_act becomes 1 only on cmd_ac while in state 2 or 3. cmd_ac in state 1 leaves tx_act at 0. tx_act returns to 0 when the block goes back to state 0.
- R7: In state 2 with sf_sync=1, irq_ai pulses and the state becomes 3 (active) once rx_act=1 has been seen on three consecutive frame_stb frames. A frame with rx_act=0 restarts the count.
- R8: If SUP_TICKS clock cycles pass in states 1 and 2 without full activation, irq_ei pulses and the state becomes 5 (fault). On the next cycle irq_di pulses and the state becomes 0.
- R9: In state 3, irq_dp pulses and the state becomes 4 (deactivation pending) after rx_dea=0 on three consecutive frames. A frame with rx_dea=1 restarts the count.
- R10: In state 4, far_sig=0 moves the block to state 0 with one irq_di pulse, and tx_en returns to 0.
- R11: If the third validating act frame completes in the same cycle as timer expiry, activation wins: irq_ai pulses, the state becomes 3 and no irq_ei is issued.
- R12: Every interrupt output is high for exactly one clock cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_tone | input | 1 | Wake-up tone detected on the line |
| pwr_up | input | 1 | Device powered up |
| cmd_ar | input | 1 | Host activation-request command pulse |
| cmd_ac | input | 1 | Host activation-control (set act) command pulse |
| sf_sync | input | 1 | Superframe sync held on the received signal |
| frame_stb | input | 1 | One-cycle strobe per received frame |
| rx_act | input | 1 | Received act bit, valid with frame_stb |
| rx_dea | input | 1 | Received dea bit, valid with frame_stb |
| far_sig | input | 1 | Far-end signal present |
| irq_lsd | output | 1 | Line-signal-detect interrupt pulse |
| irq_ap | output | 1 | Activation-pending interrupt pulse |
| irq_ai | output | 1 | Activation-indication interrupt pulse |
| irq_dp | output | 1 | Deactivation-pending interrupt pulse |
| irq_di | output | 1 | Deactivation-complete interrupt pulse |
| irq_ei | output | 1 | Error (timer expiry) interrupt pulse |
| lsd_n | output | 1 | Active-low line-signal-detect pin |
| tx_act | output | 1 | Act bit to transmit |
| tx_en | output | 1 | Transmitter enable |
| state_o | output | 3 | State code: 0 reset, 1 activating, 2 synced, 3 active, 4 deactivation pending, 5 fault |

## Verification
Two events can fall in the same cycle: the supervision timer expiring and the act validator completing its third frame. The bench counts cycles from the cycle in which it applies the activation request. It places the third act frame so that it is captured on the last cycle before expiry. It expects activation, with no error strobe. A companion case moves the third frame one cycle later and expects the error/deactivation pair on consecutive cycles, followed by reset.

// File: rtl/ntact_pkg.sv
package ntact_pkg;

    localparam int STATE_W      = 3;
    localparam int VALID_FRAMES = 3;
    localparam int N_VALID      = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_RESET      = 3'd0,
        ST_ACTIVATING = 3'd1,
        ST_SYNCED     = 3'd2,
        ST_ACTIVE     = 3'd3,
        ST_DEACT      = 3'd4,
        ST_FAULT      = 3'd5
    } seq_state_t;

    typedef struct packed {
        logic lsd;
        logic ap;
        logic ai;
        logic dp;
        logic di;
        logic ei;
    } irq_t;

    function automatic logic tx_on(seq_state_t s);
        return (s == ST_SYNCED) || (s == ST_ACTIVE) || (s == ST_DEACT);
    endfunction

    function automatic logic timed(seq_state_t s);
        return (s == ST_ACTIVATING) || (s == ST_SYNCED);
    endfunction

endpackage

// File: rtl/ntact_validator.sv
module ntact_validator #(
    parameter int FRAMES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic stb,
    input  logic bit_in,
    input  logic want,
    output logic valid
);
    localparam int CW = $clog2(FRAMES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
        end else if (stb) begin
            if (bit_in != want)
                cnt <= '0;
            else if (cnt != CW'(FRAMES))
                cnt <= cnt + 1'b1;
        end
    end

    assign valid = (cnt == CW'(FRAMES));
endmodule

// File: rtl/ntact_timer.sv
module ntact_timer #(
    parameter int unsigned TICKS = 32'd1875000000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expire
);
    localparam int TW = $clog2(TICKS + 1);

    logic [TW-1:0] tcnt;

    always_ff @(posedge clk) begin
        if (rst || !run)
            tcnt <= '0;
        else if (tcnt != TW'(TICKS - 1))
            tcnt <= tcnt + 1'b1;
    end

    assign expire = run && (tcnt == TW'(TICKS - 1));
endmodule

// File: rtl/ntact_fsm.sv
module ntact_fsm
    import ntact_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wake_tone,
    input  logic       pwr_up,
    input  logic       cmd_ar,
    input  logic       cmd_ac,
    input  logic       sf_sync,
    input  logic       far_sig,
    input  logic       act_ok,
    input  logic       dea_ok,
    input  logic       tmr_exp,
    output seq_state_t state,
    output irq_t       irq,
    output logic       tx_act,
    output logic       lsd_n
);
    logic wake_q;
    logic lsd_hold;
    logic wake_edge;

    assign wake_edge = wake_tone & ~wake_q;
    assign lsd_n     = ~lsd_hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_RESET;
            irq      <= '0;
            tx_act   <= 1'b0;
            wake_q   <= 1'b0;
            lsd_hold <= 1'b0;
        end else begin
            irq     <= '0;
            irq.lsd <= wake_edge;
            wake_q  <= wake_tone;
            if (pwr_up)
                lsd_hold <= 1'b0;
            else if (wake_edge)
                lsd_hold <= 1'b1;

            case (state)
                ST_RESET: begin
                    tx_act <= 1'b0;
                    if (pwr_up && cmd_ar)
                        state <= ST_ACTIVATING;
                end
                ST_ACTIVATING: begin
                    if (tmr_exp) begin
                        state  <= ST_FAULT;
                        irq.ei <= 1'b1;
                    end else if (sf_sync) begin
                        state  <= ST_SYNCED;
                        irq.ap <= 1'b1;
                    end
                end
                ST_SYNCED: begin
                    if (cmd_ac)
                        tx_act <= 1'b1;
                    if (sf_sync && act_ok) begin
                        state  <= ST_ACTIVE;
                        irq.ai <= 1'b1;
                    end else if (tmr_exp) begin
                        state  <= ST_FAULT;
                        irq.ei <= 1'b1;
                        tx_act <= 1'b0;
                    end
                end
                ST_ACTIVE: begin
                    if (cmd_ac)
                        tx_act <= 1'b1;
                    if (dea_ok) begin
                        state  <= ST_DEACT;
                        irq.dp <= 1'b1;
                    end
                end
                ST_DEACT: begin
                    if (!far_sig) begin
                        state  <= ST_RESET;
                        irq.di <= 1'b1;
                        tx_act <= 1'b0;
                    end
                end
                ST_FAULT: begin
                    state  <= ST_RESET;
                    irq.di <= 1'b1;
                    tx_act <= 1'b0;
                end
                default: state <= ST_RESET;
            endcase
        end
    end
endmodule

// File: rtl/ntact_seq.sv
module ntact_seq
    import ntact_pkg::*;
#(
    parameter int unsigned SUP_TICKS = 32'd1875000000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wake_tone,
    input  logic               pwr_up,
    input  logic               cmd_ar,
    input  logic               cmd_ac,
    input  logic               sf_sync,
    input  logic               frame_stb,
    input  logic               rx_act,
    input  logic               rx_dea,
    input  logic               far_sig,
    output logic               irq_lsd,
    output logic               irq_ap,
    output logic               irq_ai,
    output logic               irq_dp,
    output logic               irq_di,
    output logic               irq_ei,
    output logic               lsd_n,
    output logic               tx_act,
    output logic               tx_en,
    output logic [STATE_W-1:0] state_o
);
    seq_state_t         state;
    irq_t               irq;
    logic               tmr_exp;
    logic [N_VALID-1:0] v_en, v_bit, v_want, v_ok;

    // index 0: received act must read 1 while synced
    // index 1: received dea must read 0 while active
    assign v_en   = {state == ST_ACTIVE, state == ST_SYNCED};
    assign v_bit  = {rx_dea, rx_act};
    assign v_want = 2'b01;

    for (genvar i = 0; i < N_VALID; i++) begin : g_val
        ntact_validator #(.FRAMES(VALID_FRAMES)) u_val (
            .clk   (clk),
            .rst   (rst),
            .en    (v_en[i]),
            .stb   (frame_stb),
            .bit_in(v_bit[i]),
            .want  (v_want[i]),
            .valid (v_ok[i])
        );
    end

    ntact_timer #(.TICKS(SUP_TICKS)) u_tmr (
        .clk   (clk),
        .rst   (rst),
        .run   (timed(state)),
        .expire(tmr_exp)
    );

    ntact_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .wake_tone(wake_tone),
        .pwr_up   (pwr_up),
        .cmd_ar   (cmd_ar),
        .cmd_ac   (cmd_ac),
        .sf_sync  (sf_sync),
        .far_sig  (far_sig),
        .act_ok   (v_ok[0]),
        .dea_ok   (v_ok[1]),
        .tmr_exp  (tmr_exp),
        .state    (state),
        .irq      (irq),
        .tx_act   (tx_act),
        .lsd_n    (lsd_n)
    );

    assign irq_lsd = irq.lsd;
    assign irq_ap  = irq.ap;
    assign irq_ai  = irq.ai;
    assign irq_dp  = irq.dp;
    assign irq_di  = irq.di;
    assign irq_ei  = irq.ei;
    assign tx_en   = tx_on(state);
    assign state_o = state;
endmodule

// File: rtl/ntact_seq_chk.sv
module ntact_seq_chk
    import ntact_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               cmd_ar,
    input logic               pwr_up,
    input logic               far_sig,
    input logic               irq_ap,
    input logic               irq_ai,
    input logic               irq_dp,
    input logic               irq_di,
    input logic               irq_ei,
    input logic               tx_act,
    input logic               tx_en,
    input logic [STATE_W-1:0] state_o
);
    AST_EI_THEN_DI: assert property (@(posedge clk) disable iff (rst)
        irq_ei |=> irq_di);                                                  // R8
    AST_EI_IN_FAULT: assert property (@(posedge clk) disable iff (rst)
        irq_ei |-> state_o == ST_FAULT);                                     // R8
    AST_FAULT_LEAVES: assert property (@(posedge clk) disable iff (rst)
        state_o == ST_FAULT |=> state_o == ST_RESET);                        // R8
    AST_AI_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        irq_ai |-> state_o == ST_ACTIVE && !irq_ei);                         // R7
    AST_AP_SYNCED: assert property (@(posedge clk) disable iff (rst)
        irq_ap |-> state_o == ST_SYNCED && tx_en && !tx_act);                // R5
    AST_DP_DEACT: assert property (@(posedge clk) disable iff (rst)
        irq_dp |-> state_o == ST_DEACT);                                     // R9
    AST_TXACT_STATE: assert property (@(posedge clk) disable iff (rst)
        tx_act |-> state_o inside {ST_SYNCED, ST_ACTIVE, ST_DEACT});         // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        state_o == ST_RESET |-> !tx_en && !tx_act);                          // R10
    AST_DEACT_EXIT: assert property (@(posedge clk) disable iff (rst)
        state_o == ST_DEACT && !far_sig |=> state_o == ST_RESET && irq_di);  // R10
    AST_AR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        state_o == ST_RESET && cmd_ar && !pwr_up |=> state_o == ST_RESET);   // R4
    AST_PULSE_AI: assert property (@(posedge clk) disable iff (rst)
        irq_ai |=> !irq_ai);                                                 // R12
    AST_PULSE_DI: assert property (@(posedge clk) disable iff (rst)
        irq_di |=> !irq_di);                                                 // R12
    AST_PULSE_DP: assert property (@(posedge clk) disable iff (rst)
        irq_dp |=> !irq_dp);                                                 // R12
endmodule

bind ntact_seq ntact_seq_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .cmd_ar (cmd_ar),
    .pwr_up (pwr_up),
    .far_sig(far_sig),
    .irq_ap (irq_ap),
    .irq_ai (irq_ai),
    .irq_dp (irq_dp),
    .irq_di (irq_di),
    .irq_ei (irq_ei),
    .tx_act (tx_act),
    .tx_en  (tx_en),
    .state_o(state_o)
);

// File: tb/sim_ntact_seq.sv
`timescale 1ns/1ps
module sim_ntact_seq;
    localparam int unsigned SUP = 200;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wake_tone = 0, pwr_up = 0, cmd_ar = 0, cmd_ac = 0, sf_sync = 0;
    logic frame_stb = 0, rx_act = 0, rx_dea = 1, far_sig = 1;
    logic irq_lsd, irq_ap, irq_ai, irq_dp, irq_di, irq_ei;
    logic lsd_n, tx_act, tx_en;
    logic [2:0] state_o;

    int checks = 0, fails = 0;
    bit done = 0;
    int cyc = 0;
    int n_lsd = 0, n_ap = 0, n_ai = 0, n_dp = 0, n_di = 0, n_ei = 0, n_wide = 0;
    int ei_cyc = -1, di_cyc = -1;
    logic [5:0] prev_irq = '0;

    always #4 clk = ~clk;

    ntact_seq #(.SUP_TICKS(SUP)) u0 (.*);

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst) begin
            if (irq_lsd) n_lsd++;
            if (irq_ap) n_ap++;
            if (irq_ai) n_ai++;
            if (irq_dp) n_dp++;
            if (irq_di) begin n_di++; di_cyc = cyc; end
            if (irq_ei) begin n_ei++; ei_cyc = cyc; end
            if ((prev_irq & {irq_lsd, irq_ap, irq_ai, irq_dp, irq_di, irq_ei}) != 0) n_wide++;
            prev_irq = {irq_lsd, irq_ap, irq_ai, irq_dp, irq_di, irq_ei};
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_ar();
        @(negedge clk); cmd_ar = 1;
        @(negedge clk); cmd_ar = 0;
    endtask

    task automatic pulse_ac();
        @(negedge clk); cmd_ac = 1;
        @(negedge clk); cmd_ac = 0;
    endtask

    task automatic frame(input logic a, input logic d);
        @(negedge clk); frame_stb = 1; rx_act = a; rx_dea = d;
        @(negedge clk); frame_stb = 0; rx_act = 0; rx_dea = 1;
        idle(2);
    endtask

    task automatic strobe_at(input int t);
        while (cyc != t) @(negedge clk);
        frame_stb = 1; rx_act = 1;
        @(negedge clk); frame_stb = 0; rx_act = 0;
    endtask

    task automatic t_reset();
        idle(2);
        chk("R1 state", state_o, 0);
        chk("R1 lsd_n", lsd_n, 1);
        chk("R1 tx_en/tx_act", {tx_en, tx_act}, 0);
        chk("R1 irqs", {irq_lsd, irq_ap, irq_ai, irq_dp, irq_di, irq_ei}, 0);
    endtask

    task automatic t_wake();
        int b;
        b = n_lsd;
        @(negedge clk); wake_tone = 1;
        idle(3);
        chk("R2 lsd irq powered down", n_lsd - b, 1);
        chk("R3 pin low powered down", lsd_n, 0);
        wake_tone = 0; idle(3);
        chk("R3 pin holds after tone ends", lsd_n, 0);
        pwr_up = 1; idle(3);
        chk("R3 pin released on power up", lsd_n, 1);
        wake_tone = 1; idle(3); wake_tone = 0; idle(2);
        chk("R2 lsd irq powered up", n_lsd - b, 2);
        chk("R3 pin stays high when powered", lsd_n, 1);
    endtask

    task automatic t_ar_ignored();
        pwr_up = 0;
        pulse_ar(); idle(3);
        chk("R4 AR ignored while down", state_o, 0);
        pwr_up = 1; idle(1);
    endtask

    task automatic t_deact();
        int bdp, bdi;
        bdp = n_dp; bdi = n_di;
        frame(0, 0); frame(0, 0); frame(0, 1); frame(0, 0); frame(0, 0);
        chk("R9 dea restart no dp", n_dp - bdp, 0);
        chk("R9 still active", state_o, 3);
        frame(0, 0);
        chk("R9 dp after three", n_dp - bdp, 1);
        chk("R9 state deact", state_o, 4);
        chk("R10 tx still on", tx_en, 1);
        @(negedge clk); far_sig = 0;
        idle(3);
        chk("R10 back to reset", state_o, 0);
        chk("R10 di once", n_di - bdi, 1);
        chk("R10 tx off", {tx_en, tx_act}, 0);
        far_sig = 1; idle(2);
    endtask

    task automatic t_activate();
        int bap, bai;
        bap = n_ap; bai = n_ai;
        pulse_ar(); idle(1);
        chk("R4 activating", state_o, 1);
        pulse_ac(); idle(1);
        chk("R6 ac ignored in activating", tx_act, 0);
        @(negedge clk); sf_sync = 1;
        idle(3);
        chk("R5 synced", state_o, 2);
        chk("R5 ap once", n_ap - bap, 1);
        chk("R5 tx_en on, act 0", {tx_en, tx_act}, 2);
        frame(1, 1); frame(1, 1); frame(0, 1); frame(1, 1); frame(1, 1);
        chk("R7 mismatch restarts", n_ai - bai, 0);
        chk("R7 still synced", state_o, 2);
        pulse_ac(); idle(1);
        chk("R6 tx_act set by ac", tx_act, 1);
        frame(1, 1);
        chk("R7 ai after three", n_ai - bai, 1);
        chk("R7 active", state_o, 3);
        t_deact();
        chk("R6 tx_act cleared in reset", tx_act, 0);
        sf_sync = 0;
    endtask

    task automatic t_timeout();
        int bei, bdi;
        bei = n_ei; bdi = n_di;
        pulse_ar();
        idle(SUP + 10);
        chk("R8 ei once", n_ei - bei, 1);
        chk("R8 di once", n_di - bdi, 1);
        chk("R8 di on cycle after ei", di_cyc - ei_cyc, 1);
        chk("R8 back to reset", state_o, 0);
    endtask

    task automatic t_race(input int shift, input bit expect_ai);
        int c, bai, bei;
        bai = n_ai; bei = n_ei;
        sf_sync = 1;
        @(negedge clk); cmd_ar = 1; c = cyc;
        @(negedge clk); cmd_ar = 0;
        strobe_at(c + SUP - 5 + shift);
        strobe_at(c + SUP - 3 + shift);
        strobe_at(c + SUP - 1 + shift);
        idle(4);
        if (expect_ai) begin
            chk("R11 tie gives ai", n_ai - bai, 1);
            chk("R11 tie gives no ei", n_ei - bei, 0);
            chk("R11 tie state active", state_o, 3);
            sf_sync = 0;
            t_deact();
        end else begin
            chk("R8 late frame gives ei", n_ei - bei, 1);
            chk("R8 late frame no ai", n_ai - bai, 0);
            chk("R8 late frame state reset", state_o, 0);
            sf_sync = 0;
        end
        idle(2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_wake();
        t_ar_ignored();
        t_activate();
        t_timeout();
        t_race(0, 1);
        t_race(1, 0);
        chk("R12 single-cycle irqs", n_wide, 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule